// File: doc/BRIEF.md
# Host Command and Event Interrupt Register Block

This block is the host-facing register window of a network controller. It collects single-cycle event pulses from a command engine and a receive engine into sticky flags. It shows the current state codes of both engines and drives a single interrupt line. Software clears flags by writing ones to a separate acknowledge byte. It can mask the interrupt line and can raise a software event.

Software issues engine commands by writing an opcode byte. The byte holds the opcode for one cycle and then reads back as zero. That return to zero is the handshake that tells software it may write the next command. One cycle later the accepted opcode is presented to the engines as a single-cycle strobe, together with the value held in a 32-bit pointer register.

The host port is a 32-bit word interface with byte enables. Word index 0 holds four bytes at byte offsets 0 to 3: status low, status high (which is also the acknowledge byte), command, and interrupt control. Word index 1 is the pointer register at byte offset 4.

Top module: `ctl_status_irq`

## Requirements
- R1: After reset, word 0 reads as the engine state fields only, with every event flag, the command byte and the mask bit zero. The interrupt output is low, no strobe is issued and the pointer reads zero.
- R2: A pulse on `evt_i[k]` sets a sticky flag in status bit 11+k, where k=4 is command done, 3 is frame received, 2 is command engine gone inactive, 1 is receive engine not ready and 0 is management transfer done. The flag stays set until it is acknowledged.
- R3: A write with byte enable 1 clears each flag in status bits 15:10 whose bit in `host_wdata[15:10]` is one, and leaves every other flag unchanged.
- R4: When an event pulse and an acknowledge of the same flag fall in the same cycle, the flag stays set.
- R5: Status bits 7:6 show `cu_state_i` (idle 00, suspended 01, active 10), bits 5:2 show `ru_state_i` (idle 0000, suspended 0001, no resources 0010, ready 0100, bit 5 a buffer flag), and bits 9:8 and 1:0 read zero.
- R6: A nonzero write to the command byte (bits 23:16, byte enable 2) reads back in the following cycle. In the cycle after that, `cmd_stb_o` is high for one cycle with `cmd_op_o` equal to the opcode, and the command byte reads zero. Command engine opcodes sit in the upper nibble (0x10 start, 0x20 resume, 0x40 to 0x70 counter and base operations) and receive engine opcodes in the lower nibble (0x01 to 0x07).
- R7: `cmd_ptr_o` carries the pointer register value as it stands in the strobe cycle.
- R8: `irq_o` is high exactly when any flag in status bits 15:10 is set and the mask bit (bit 24, byte enable 3) is zero.
- R9: Writing a one to bit 25 (byte enable 3) sets the software event flag in status bit 10. Bit 25 always reads zero, and the mask bit reads back as written.
- R10: A command byte write of 0x00 produces no strobe.
- R11: A write to word index 1 updates only the pointer bytes whose byte enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | Word index: 0 control word, 1 pointer |
| host_be_i | input | 4 | Byte enables |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data for the addressed word |
| evt_i | input | 5 | Engine event pulses (R2 mapping) |
| cu_state_i | input | 2 | Command engine state code |
| ru_state_i | input | 4 | Receive engine state code |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 8 | Accepted opcode |
| cmd_ptr_o | output | 32 | Pointer value issued with the command |
| irq_o | output | 1 | Interrupt request |

## Verification
Each event source is pulsed on its own to confirm its bit position. The acknowledge write uses mixed one/zero patterns, so a design that clears the whole byte is told apart from one that clears only the selected bits. A pulse and an acknowledge of the same flag are applied in one cycle to check which one takes priority. Command writes use a command engine opcode, a receive engine opcode and 0x00, and each is checked in the write cycle, the strobe cycle and the cycle after. These checks separate correct acceptance timing and pointer capture from off-by-one or stuck strobes.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BYTES    = DATA_W / 8;
  localparam int unsigned HW_EVT_W = 5;
  localparam int unsigned EVT_W    = HW_EVT_W + 1;
  localparam int unsigned EVT_LSB  = 10;
  localparam int unsigned SWI_IDX  = 0;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'b00,
    CU_SUSP   = 2'b01,
    CU_ACTIVE = 2'b10
  } cu_state_e;

  typedef struct packed {
    logic [EVT_W-1:0] flags;
    logic [1:0]       rsvd_hi;
    logic [1:0]       cu;
    logic [3:0]       ru;
    logic [1:0]       rsvd_lo;
  } status_t;
endpackage

// File: rtl/csi_event_bank.sv
module csi_event_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;
    logic flag_en;
    always_comb begin
      flag_en = set_i[i] | clr_i[i];
      flag_d  = set_i[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q[i] <= 1'b0;
      else if (flag_en) flag_q[i] <= flag_d;
    end
  end

  assign flags_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0)); // R3
endmodule

// File: rtl/csi_cmd_slot.sv
module csi_cmd_slot #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OP_W-1:0]  wr_op_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [OP_W-1:0]  pend_o,
  output logic             stb_o,
  output logic [OP_W-1:0]  op_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic [OP_W-1:0]  pend_q, pend_d;
  logic             stb_q, stb_d;
  logic [OP_W-1:0]  op_q;
  logic [PTR_W-1:0] ptr_q;
  logic             issue;
  logic             pend_en;

  always_comb begin
    issue   = (pend_q != '0);
    pend_en = wr_en_i | issue;
    pend_d  = wr_en_i ? wr_op_i : '0;
    stb_d   = issue;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      ptr_q <= '0;
    end else if (issue) begin
      op_q  <= pend_q;
      ptr_q <= ptr_i;
    end
  end

  assign pend_o = pend_q;
  assign stb_o  = stb_q;
  assign op_o   = op_q;
  assign ptr_o  = ptr_q;

  AST_CMD_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |=> (stb_o && (op_o == $past(pend_q)))); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |=> !stb_o); // R10
  AST_PEND_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i) |=> (pend_o == '0)); // R6
endmodule

// File: rtl/ctl_status_irq.sv
module ctl_status_irq
  import csi_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_we_i,
  input  logic                host_addr_i,
  input  logic [BYTES-1:0]    host_be_i,
  input  logic [DATA_W-1:0]   host_wdata_i,
  output logic [DATA_W-1:0]   host_rdata_o,
  input  logic [HW_EVT_W-1:0] evt_i,
  input  logic [1:0]          cu_state_i,
  input  logic [3:0]          ru_state_i,
  output logic                cmd_stb_o,
  output logic [7:0]          cmd_op_o,
  output logic [DATA_W-1:0]   cmd_ptr_o,
  output logic                irq_o
);
  localparam int unsigned ACK_LANE = 1;
  localparam int unsigned CMD_LANE = 2;
  localparam int unsigned ICR_LANE = 3;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic ctl_wr, ptr_wr;
  assign ctl_wr = host_we_i & ~host_addr_i;
  assign ptr_wr = host_we_i &  host_addr_i;

  logic [DATA_W-1:0] ptr_q;
  for (genvar b = 0; b < BYTES; b++) begin : g_ptr_lane
    logic lane_en;
    assign lane_en = ptr_wr & host_be_i[b];
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)       ptr_q[8*b +: 8] <= '0;
      else if (lane_en) ptr_q[8*b +: 8] <= host_wdata_i[8*b +: 8];
    end
  end

  logic mask_q, mask_d, mask_en;
  logic swi_wr;
  always_comb begin
    mask_en = ctl_wr & host_be_i[ICR_LANE];
    mask_d  = host_wdata_i[8*ICR_LANE];
    swi_wr  = mask_en & host_wdata_i[8*ICR_LANE+1];
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b0;
    else if (mask_en) mask_q <= mask_d;
  end

  logic [EVT_W-1:0] evt_set, evt_clr, flags;
  always_comb begin
    evt_set          = {evt_i, 1'b0};
    evt_set[SWI_IDX] = swi_wr;
    evt_clr          = (ctl_wr & host_be_i[ACK_LANE])
                     ? host_wdata_i[EVT_LSB +: EVT_W] : '0;
  end

  csi_event_bank #(.N(EVT_W)) u_events (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .set_i   (evt_set),
    .clr_i   (evt_clr),
    .flags_o (flags)
  );

  logic [7:0] cmd_pend;
  csi_cmd_slot #(.OP_W(8), .PTR_W(DATA_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_en_i (ctl_wr & host_be_i[CMD_LANE] & (host_wdata_i[8*CMD_LANE +: 8] != 8'h00)),
    .wr_op_i (host_wdata_i[8*CMD_LANE +: 8]),
    .ptr_i   (ptr_q),
    .pend_o  (cmd_pend),
    .stb_o   (cmd_stb_o),
    .op_o    (cmd_op_o),
    .ptr_o   (cmd_ptr_o)
  );

  status_t status;
  always_comb begin
    status.flags   = flags;
    status.rsvd_hi = 2'b00;
    status.cu      = cu_state_i;
    status.ru      = ru_state_i;
    status.rsvd_lo = 2'b00;
  end

  always_comb begin
    if (host_addr_i) host_rdata_o = ptr_q;
    else             host_rdata_o = {7'b0, mask_q, cmd_pend, status};
  end

  assign irq_o = (|flags) & ~mask_q;

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata_i[31:26], host_wdata_i[9:8]};

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    mask_q |-> !irq_o); // R8
  AST_SWI_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    swi_wr |=> host_rdata_o[EVT_LSB] || host_addr_i); // R9
endmodule

// File: tb/ctl_status_irq_tb.sv
module ctl_status_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic        addr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [4:0]  evt;
  logic [1:0]  cu;
  logic [3:0]  ru;
  logic        stb;
  logic [7:0]  op;
  logic [31:0] cptr;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #5 clk = ~clk;

  ctl_status_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_be_i(be), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .evt_i(evt), .cu_state_i(cu), .ru_state_i(ru),
    .cmd_stb_o(stb), .cmd_op_o(op), .cmd_ptr_o(cptr), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    we = 1'b0; be = 4'h0; addr = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    addr = 1'b0;
    chk(rdata, 32'h0, "R1 word0");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk({31'b0, stb}, 32'h0, "R1 stb");
    addr = 1'b1; #1;
    chk(rdata, 32'h0, "R1 ptr");
    addr = 1'b0;
  endtask

  task automatic t_states;
    cu = 2'b10; ru = 4'b0100; #1;
    chk(rdata, 32'h0000_0090, "R5 active/ready");
    cu = 2'b01; ru = 4'b1010; #1;
    chk(rdata, 32'h0000_0068, "R5 susp/nores+buf");
    cu = 2'b00; ru = 4'b0000; #1;
  endtask

  task automatic t_events;
    for (int k = 0; k < 5; k++) begin
      pulse(5'b1 << k);
      chk(rdata[15:8], 8'h08 << k, "R2 bit position");
      chk({31'b0, irq}, 32'h1, "R8 irq on event");
      wr(1'b0, 4'b0010, 32'h0000_FC00);
      chk(rdata[15:8], 8'h00, "R3 clear all");
    end
    chk({31'b0, irq}, 32'h0, "R8 irq idle");
  endtask

  task automatic t_ack_partial;
    pulse(5'b11111);
    chk(rdata[15:8], 8'hF8, "R2 all set");
    wr(1'b0, 4'b0010, 32'h0000_A400);
    chk(rdata[15:8], 8'h58, "R3 partial ack");
    wr(1'b0, 4'b0001, 32'h0000_FFFF);
    chk(rdata[15:8], 8'h58, "R3 no lane-1 enable");
    @(negedge clk);
    evt = 5'b00100; we = 1'b1; be = 4'b0010; wdata = 32'h0000_7C00;
    @(negedge clk);
    evt = '0; we = 1'b0; be = 4'h0;
    chk(rdata[15:8], 8'h20, "R4 event beats ack");
    wr(1'b0, 4'b0010, 32'h0000_FC00);
  endtask

  task automatic t_mask_swi;
    wr(1'b0, 4'b1000, 32'h0100_0000);
    chk(rdata[31:24], 8'h01, "R9 mask readback");
    pulse(5'b00010);
    chk({31'b0, irq}, 32'h0, "R8 masked");
    wr(1'b0, 4'b1000, 32'h0000_0000);
    chk({31'b0, irq}, 32'h1, "R8 unmasked");
    wr(1'b0, 4'b0010, 32'h0000_FC00);
    wr(1'b0, 4'b1000, 32'h0200_0000);
    chk(rdata[15:8], 8'h04, "R9 swi flag");
    chk(rdata[31:24], 8'h00, "R9 bit reads zero");
    chk({31'b0, irq}, 32'h1, "R8 swi irq");
    wr(1'b0, 4'b0010, 32'h0000_0400);
    chk({31'b0, irq}, 32'h0, "R3 swi ack");
  endtask

  task automatic t_cmd(input logic [7:0] opc, input logic [31:0] pv);
    wr(1'b1, 4'b1111, pv);
    wr(1'b0, 4'b0100, {8'h0, opc, 16'h0});
    chk(rdata[23:16], opc, "R6 byte held");
    chk({31'b0, stb}, 32'h0, "R6 no early strobe");
    @(negedge clk);
    chk({31'b0, stb}, 32'h1, "R6 strobe");
    chk({24'b0, op}, {24'b0, opc}, "R6 opcode");
    chk(cptr, pv, "R7 pointer");
    chk(rdata[23:16], 8'h00, "R6 byte cleared");
    @(negedge clk);
    chk({31'b0, stb}, 32'h0, "R6 one cycle");
  endtask

  task automatic t_cmd_zero;
    wr(1'b0, 4'b0100, 32'h0);
    chk({31'b0, stb}, 32'h0, "R10 nop a");
    @(negedge clk);
    chk({31'b0, stb}, 32'h0, "R10 nop b");
  endtask

  task automatic t_ptr_lane;
    wr(1'b1, 4'b1111, 32'h1234_5678);
    wr(1'b1, 4'b0010, 32'hFFFF_AAFF);
    addr = 1'b1; #1;
    chk(rdata, 32'h1234_AA78, "R11 lane write");
    addr = 1'b0;
  endtask

  initial begin
    #150000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = 1'b0; be = '0; wdata = '0;
    evt = '0; cu = 2'b00; ru = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_states;
    t_events;
    t_ack_partial;
    t_mask_swi;
    t_cmd(8'h10, 32'hCAFE_0010);
    t_cmd(8'h05, 32'h0000_BEEF);
    t_cmd_zero;
    t_ptr_lane;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule